// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one N-bit unsigned integer by another over many clock cycles and uses one shared adder/subtractor. A pulse on `start` while the block is idle captures both operands. The divisor sits in the upper half of a 2N-bit register that moves one place right on every iteration. The dividend, widened to 2N bits, becomes the running remainder. Each iteration writes the remainder minus the shifted divisor into the remainder register. If that result is negative, the iteration adds the divisor back and shifts a 0 into the quotient. Otherwise it keeps the difference and shifts in a 1. After N+1 iterations the quotient register and the low half of the remainder register hold the result.

`start`, `busy` and `done` are plain control pins. The operands are sampled only on the accepting edge. The results stay on the output pins until the next accepted start, so a consumer can read them at any time after `done`. There is no back-pressure: `done` is a one-cycle notice and the result does not need to be taken on that cycle. A divisor of zero is not trapped and gives a fixed, defined result.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` that is high at a rising edge while `busy` is 0 is accepted, and `busy` reads 1 in the cycle after that edge.
- R3: For a nonzero divisor, the result is `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor. This holds over the full N-bit range, including a dividend smaller than the divisor, a dividend of zero and a divisor of one.
- R4: Each iteration takes three clock edges: subtract, then restore or keep, then shift the divisor. There are N+1 iterations, plus one load edge and one finishing edge. `done` is therefore high in the cycle after the (3N+4)th rising edge that follows the accepting edge.
- R5: `done` is high for exactly one cycle, `busy` is 0 whenever `done` is 1, and `busy` stays 1 from the cycle after acceptance until `done` rises.
- R6: A `start` pulse while `busy` is 1 is ignored. The running division finishes with the first operands, at the time set by R4, and no extra `done` follows.
- R7: While idle, `quotient` and `remainder` keep their last values until the next accepted start.
- R8: With a divisor of zero, `quotient` is all ones and `remainder` equals the dividend.
- R9: A `start` given in the same cycle that `done` is high is accepted, so divisions can follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | N | Unsigned dividend, sampled when start is accepted |
| divisor | input | N | Unsigned divisor, sampled when start is accepted |
| quotient | output | N | Quotient result |
| remainder | output | N | Low N bits of the remainder register |
| done | output | 1 | One-cycle pulse when the result is final |
| busy | output | 1 | High while a division is running |

## Verification
The operand pairs are chosen so that the iterations take different paths. A dividend below the divisor restores on every iteration. A divisor of one keeps the difference on every late iteration. Equal operands and an all-ones dividend over a large divisor test the borrow at the top of the 2N-bit subtraction, which a plain top-bit test would read wrongly. A zero divisor checks the defined all-ones quotient. A swept series of mixed operand pairs mixes restore and keep iterations. Starting new divisions on the `done` cycle, and pulsing `start` in the middle of a run, separate correct acceptance from a restart or a lost request.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUB,
    ST_FIX,
    ST_SHIFT,
    ST_FIN
  } div_state_e;

  typedef enum logic {
    ALU_SUB,
    ALU_ADD
  } alu_op_e;
endpackage

// File: rtl/div_alu.sv
module div_alu
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   y
);
  // One extra bit on top: for a subtraction it is the borrow (result negative).
  always_comb begin
    if (op == ALU_SUB) y = {1'b0, a} - {1'b0, b};
    else               y = {1'b0, a} + {1'b0, b};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic do_sub,
  output logic do_fix,
  output logic do_shift,
  output logic busy,
  output logic done
);
  localparam int ITERS = N + 1;
  localparam int CW    = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(ITERS - 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] iter_q, iter_d;

  always_comb begin
    state_d  = state_q;
    iter_d   = iter_q;
    load     = 1'b0;
    do_sub   = 1'b0;
    do_fix   = 1'b0;
    do_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          iter_d  = '0;
          state_d = ST_SUB;
        end
      end
      ST_SUB: begin
        do_sub  = 1'b1;
        state_d = ST_FIX;
      end
      ST_FIX: begin
        do_fix  = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        do_shift = 1'b1;
        if (iter_q == LAST_ITER) begin
          state_d = ST_FIN;
        end else begin
          iter_d  = iter_q + 1'b1;
          state_d = ST_SUB;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
      done    <= (state_q == ST_FIN);
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         do_sub,
  input  logic         do_fix,
  input  logic         do_shift,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  localparam int W = 2 * N;

  logic [W-1:0] dvsr_q;
  logic [W-1:0] rem_q;
  logic         neg_q;
  logic [N-1:0] quo_q;
  alu_op_e      op;
  logic [W:0]   alu_y;

  assign op = do_fix ? ALU_ADD : ALU_SUB;

  div_alu #(.W(W)) u_alu (
    .op (op),
    .a  (rem_q),
    .b  (dvsr_q),
    .y  (alu_y)
  );

  // Divisor register: loaded into the upper half, moved right once per iteration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dvsr_q <= '0;
    else if (load)     dvsr_q <= {divisor, {N{1'b0}}};
    else if (do_shift) dvsr_q <= dvsr_q >> 1;
  end

  // Remainder register and the borrow flag kept beside it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      neg_q <= 1'b0;
    end else if (load) begin
      rem_q <= {{N{1'b0}}, dividend};
      neg_q <= 1'b0;
    end else if (do_sub) begin
      rem_q <= alu_y[W-1:0];
      neg_q <= alu_y[W];
    end else if (do_fix && neg_q) begin
      rem_q <= alu_y[W-1:0];
    end
  end

  // Quotient register: shifts left with the outcome of the test.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      quo_q <= '0;
    else if (load)   quo_q <= '0;
    else if (do_fix) quo_q <= {quo_q[N-2:0], ~neg_q};
  end

  assign quotient  = quo_q;
  assign remainder = rem_q[N-1:0];
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         done,
  output logic         busy
);
  logic load, do_sub, do_fix, do_shift;

  div_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (load),
    .do_sub   (do_sub),
    .do_fix   (do_fix),
    .do_shift (do_shift),
    .busy     (busy),
    .done     (done)
  );

  div_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .do_sub    (do_sub),
    .do_fix    (do_fix),
    .do_shift  (do_shift),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder,
  input logic         done,
  input logic         busy
);
  localparam int LAT = 3 * N + 4;

  logic [N-1:0] cap_a, cap_b;
  logic [15:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cnt   <= '0;
    end else if (start && !busy) begin
      cap_a <= dividend;
      cap_b <= divisor;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b != '0) |-> (quotient == cap_a / cap_b && remainder == cap_a % cap_b));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == 16'(LAT)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(quotient) && $stable(remainder)));

  assert_zero_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b == '0) |-> (quotient == '1 && remainder == cap_a));
endmodule

bind restoring_divider restoring_divider_chk #(.N(N)) u_chk (.*);

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
  localparam int N   = 8;
  localparam int LAT = 3 * N + 4;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] q;
    logic [N-1:0] r;
    int           due;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic [N-1:0] quotient, remainder;
  logic         done, busy;

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  int   pushed = 0;
  int   popped = 0;
  exp_t sb[$];
  exp_t last;

  restoring_divider #(.N(N)) u_restoring_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done),
    .busy      (busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: waits for idle at a falling edge, applies one start, pushes the expectation.
  task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b);
    exp_t e;
    while (busy) @(negedge clk);
    start    = 1'b1;
    dividend = a;
    divisor  = b;
    e.a   = a;
    e.b   = b;
    e.q   = (b == 0) ? '1 : a / b;
    e.r   = (b == 0) ? a : a % b;
    e.due = cyc + 1 + LAT;
    sb.push_back(e);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each result as done appears.
  initial begin
    exp_t e;
    logic prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_done) check(done == 1'b0, "R5 done single pulse", int'(done), 0);
      if (done) begin
        check(busy == 1'b0, "R5 busy low with done", int'(busy), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          popped++;
          last = e;
          if (e.b == 0) begin
            check(quotient == e.q, "R8 zero-divisor quotient", int'(quotient), int'(e.q));
            check(remainder == e.r, "R8 zero-divisor remainder", int'(remainder), int'(e.r));
          end else begin
            check(quotient == e.q, "R3 quotient", int'(quotient), int'(e.q));
            check(remainder == e.r, "R3 remainder", int'(remainder), int'(e.r));
          end
          check(cyc == e.due, "R4 done timing", cyc, e.due);
        end
      end
      prev_done = done;
    end
  end

  // Watchdog
  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 control after reset", int'({busy, done}), 0);
    check(quotient == '0 && remainder == '0, "R1 outputs after reset",
          int'({quotient, remainder}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 directed patterns
    launch(8'd74, 8'd21);
    drain();
    launch(8'd7, 8'd2);
    launch(8'd0, 8'd5);     // R9: back-to-back accept on the done cycle
    launch(8'd255, 8'd1);
    launch(8'd255, 8'd255);
    launch(8'd3, 8'd200);
    launch(8'd200, 8'd3);
    launch(8'd128, 8'd255);
    drain();
    check(popped == pushed, "R9 back-to-back results", popped, pushed);

    // R8 zero divisor
    launch(8'd100, 8'd0);
    launch(8'd0, 8'd0);
    drain();

    // R6 start while busy is ignored
    launch(8'd74, 8'd21);
    repeat (4) @(negedge clk);
    start = 1'b1; dividend = 8'd9; divisor = 8'd9;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (LAT + 6) @(negedge clk);
    check(popped == pushed, "R6 no extra done", popped, pushed);

    // R7 hold while idle
    check(quotient == last.q, "R7 quotient held", int'(quotient), int'(last.q));
    check(remainder == last.r, "R7 remainder held", int'(remainder), int'(last.r));
    dividend = 8'd1; divisor = 8'd1;
    repeat (3) @(negedge clk);
    check(quotient == 8'd3 && remainder == 8'd11, "R7 inputs ignored while idle",
          int'({quotient, remainder}), int'({8'd3, 8'd11}));

    // R3 sweep of mixed operands
    for (int i = 0; i < 24; i++) begin
      launch(8'((i * 37 + 11) % 256), 8'((i * 13 + 1) % 256));
    end
    drain();
    check(popped == pushed, "R3 all results seen", popped, pushed);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule